// File: doc/BRIEF.md
# Debug Access Gate with Retire-Count Auto-Enable

This block decides whether an external debug interface may act on the core. After reset it holds debug access off. This gives reset-timing attacks no window to work with. The block counts retired instructions and opens debug by itself once a parameterised count is reached. Firmware can step in before that point, or at any later time.

Firmware has a single write port with two bits: an enable bit and a sticky bit. A write with the enable bit clear and the sticky bit clear is a soft disable. Firmware can undo it later with an enable write, for example after a challenge-response exchange handled in software. A write with the enable bit clear and the sticky bit set is a lock that only a reset removes. Any firmware write counts as a decision. After a decision the retire counter freezes and automatic enable can no longer happen. A two-bit state output and a lock flag report where the gate stands.

Top module: `dbg_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `state_o` is 2'b00 (countdown), `dbg_en_o` is 0 and `locked_o` is 0.
- R2: With no firmware write, `dbg_en_o` stays 0 through the first THRESH-1 retire pulses. It becomes 1 on the clock edge that samples the THRESH-th retire pulse. THRESH defaults to 4096.
- R3: A firmware write during countdown ends the countdown for good. After that write, no number of retire pulses can change the state.
- R4: Write decode: `wr_data_i[0]` is the enable bit and `wr_data_i[1]` is the sticky bit. When the enable bit is 1, the next state is open (the sticky bit is ignored). When the enable bit is 0 and the sticky bit is 0, the next state is soft-disabled. When the enable bit is 0 and the sticky bit is 1, the next state is locked. The change takes effect on the edge that samples the write.
- R5: The locked state persists until reset. Every firmware write is ignored while locked, debug stays off, and `locked_o` is 1.
- R6: In the soft-disabled state, debug is off and retire pulses have no effect. An enable write moves the gate to the open state.
- R7: The retire counter saturates at THRESH and does not change once the gate has left countdown.
- R8: Status encoding on `state_o`: 2'b00 countdown, 2'b01 open, 2'b10 soft-disabled, 2'b11 locked. `dbg_en_o` is 1 only in the open state.
- R9: When a firmware write arrives in the same cycle as the THRESH-th retire pulse, the write wins.
- R10: From the open state, a disable write revokes access. It moves the gate to soft-disabled or locked, according to the sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One pulse per retired instruction |
| wr_i | input | 1 | Firmware write strobe |
| wr_data_i | input | 2 | Write data: bit 0 enable, bit 1 sticky |
| state_o | output | 2 | Gate state code |
| dbg_en_o | output | 1 | Debug access permitted |
| locked_o | output | 1 | Sticky lock active |

## Verification
The assertions assume that `retire_i` and `wr_i` are synchronous single-cycle strobes. They also assume that `wr_data_i` is meaningful only while `wr_i` is high. The stimulus drives every strobe for exactly one cycle, changes inputs only on the falling edge, and holds `wr_data_i` at zero when no write is made. Long retire runs carry no write, except in the deliberate same-cycle collision case.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  typedef enum logic [1:0] {
    ST_COUNT = 2'b00,
    ST_OPEN  = 2'b01,
    ST_SOFT  = 2'b10,
    ST_LOCK  = 2'b11
  } gate_st_e;

  localparam int unsigned WR_EN_BIT     = 0;
  localparam int unsigned WR_STICKY_BIT = 1;
  localparam int unsigned WR_W          = 2;
endpackage

// File: rtl/dbg_retire_cnt.sv
module dbg_retire_cnt #(
  parameter int unsigned THRESH = 4096,
  localparam int unsigned CW    = $clog2(THRESH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          retire_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full     = (cnt_q == CW'(THRESH));
  assign expire_o = run_i & retire_i & (cnt_q == CW'(THRESH - 1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (run_i && retire_i && !full) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/dbg_gate_fsm.sv
module dbg_gate_fsm
  import dbg_gate_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            expire_i,
  output gate_st_e        state_o
);
  gate_st_e state_q, state_d, wr_tgt;

  // firmware decision target; enable bit dominates sticky bit
  always_comb begin
    if (wr_data_i[WR_EN_BIT])          wr_tgt = ST_OPEN;
    else if (wr_data_i[WR_STICKY_BIT]) wr_tgt = ST_LOCK;
    else                               wr_tgt = ST_SOFT;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COUNT: begin
        if (wr_i)          state_d = wr_tgt;   // write beats expiry
        else if (expire_i) state_d = ST_OPEN;
      end
      ST_OPEN, ST_SOFT: if (wr_i) state_d = wr_tgt;
      ST_LOCK: state_d = ST_LOCK;
      default: state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_COUNT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dbg_gate.sv
module dbg_gate
  import dbg_gate_pkg::*;
#(
  parameter int unsigned THRESH = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       retire_i,
  input  logic       wr_i,
  input  logic [1:0] wr_data_i,
  output logic [1:0] state_o,
  output logic       dbg_en_o,
  output logic       locked_o
);
  localparam int unsigned CW = $clog2(THRESH + 1);

  gate_st_e      st;
  logic          expire;
  logic [CW-1:0] cnt_w;

  dbg_retire_cnt #(.THRESH(THRESH)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (st == ST_COUNT),
    .retire_i (retire_i),
    .cnt_o    (cnt_w),
    .expire_o (expire)
  );

  dbg_gate_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .expire_i  (expire),
    .state_o   (st)
  );

  assign state_o  = st;
  assign dbg_en_o = (st == ST_OPEN);
  assign locked_o = (st == ST_LOCK);
endmodule

// File: rtl/dbg_gate_chk.sv
module dbg_gate_chk #(
  parameter int unsigned THRESH = 4096,
  parameter int unsigned CW     = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          retire_i,
  input logic          wr_i,
  input logic [1:0]    wr_data_i,
  input logic [1:0]    state_o,
  input logic          dbg_en_o,
  input logic          locked_o,
  input logic [CW-1:0] cnt_i
);
  p_countdown_closed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00) |-> !dbg_en_o);

  p_no_return_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'b00) |=> (state_o != 2'b00));

  p_lock_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b11) |=> (state_o == 2'b11) && locked_o && !dbg_en_o);

  p_soft_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10) && !wr_i |=> (state_o == 2'b10));

  p_cnt_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CW'(THRESH)) |=> (cnt_i == CW'(THRESH)));

  p_cnt_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'b00) |=> $stable(cnt_i));

  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00) && wr_i && !wr_data_i[0] |=> !dbg_en_o);

  p_revoke_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b01) && wr_i && !wr_data_i[0] |=> !dbg_en_o);
endmodule

bind dbg_gate dbg_gate_chk #(.THRESH(THRESH), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .retire_i  (retire_i),
  .wr_i      (wr_i),
  .wr_data_i (wr_data_i),
  .state_o   (state_o),
  .dbg_en_o  (dbg_en_o),
  .locked_o  (locked_o),
  .cnt_i     (cnt_w)
);

// File: tb/tb_dbg_gate.sv
module tb_dbg_gate;
  localparam int THR = 4096;
  localparam logic [1:0] S_CNT = 2'b00, S_OPEN = 2'b01, S_SOFT = 2'b10, S_LOCK = 2'b11;
  localparam logic [1:0] W_SOFT = 2'b00, W_EN = 2'b01, W_LOCK = 2'b10, W_ENST = 2'b11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic retire_i = 1'b0;
  logic wr_i = 1'b0;
  logic [1:0] wr_data_i = 2'b00;
  logic [1:0] state_o;
  logic dbg_en_o, locked_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] st;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  dbg_gate #(.THRESH(THR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .retire_i(retire_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .state_o(state_o), .dbg_en_o(dbg_en_o), .locked_o(locked_o)
  );

  // monitor: compare outputs against queued expectations away from the edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      exp_t e;
      logic [3:0] act, exv;
      e = sb_q.pop_front();
      act = {state_o, dbg_en_o, locked_o};
      exv = {e.st, e.st == S_OPEN, e.st == S_LOCK};
      checks++;
      if (act !== exv) begin
        errors++;
        $display("FAIL %s: actual {st,en,lk}=%b expected %b", e.tag, act, exv);
      end
    end
  end

  task automatic expect_st(input logic [1:0] st, input string tag);
    exp_t e;
    e.st = st; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic cyc(input logic ret, input logic wr, input logic [1:0] d);
    @(negedge clk);
    retire_i = ret; wr_i = wr; wr_data_i = d;
    @(posedge clk); #1;
    retire_i = 1'b0; wr_i = 1'b0; wr_data_i = 2'b00;
  endtask

  task automatic retires(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'b00);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    expect_st(S_CNT, "R1 in reset");
    rst_ni = 1'b1;
    expect_st(S_CNT, "R1 after release");

    // R2 auto enable at THR-th retire
    retires(THR - 1);
    expect_st(S_CNT, "R2 before threshold");
    retires(1);
    expect_st(S_OPEN, "R2 at threshold R8");

    // R10 revoke, R6 soft behaviour, R5 lock
    cyc(1'b0, 1'b1, W_SOFT);
    expect_st(S_SOFT, "R10 soft revoke");
    retires(10);
    expect_st(S_SOFT, "R6 retires ignored");
    cyc(1'b0, 1'b1, W_EN);
    expect_st(S_OPEN, "R6 re-enable");
    cyc(1'b0, 1'b1, W_LOCK);
    expect_st(S_LOCK, "R10 lock from open");
    cyc(1'b0, 1'b1, W_EN);
    expect_st(S_LOCK, "R5 enable ignored");
    cyc(1'b0, 1'b1, W_SOFT);
    expect_st(S_LOCK, "R5 soft ignored");
    retires(20);
    expect_st(S_LOCK, "R5 retires ignored");

    // R3 / R7: early soft disable freezes countdown
    do_reset();
    expect_st(S_CNT, "R1 second reset");
    retires(100);
    cyc(1'b0, 1'b1, W_SOFT);
    expect_st(S_SOFT, "R3 early soft");
    retires(THR + 100);
    expect_st(S_SOFT, "R7 counter frozen R3");
    cyc(1'b0, 1'b1, W_EN);
    expect_st(S_OPEN, "R4 enable from soft");

    // R9 write collides with final retire
    do_reset();
    retires(THR - 1);
    expect_st(S_CNT, "R9 pre-collision");
    cyc(1'b1, 1'b1, W_SOFT);
    expect_st(S_SOFT, "R9 write wins");
    retires(5);
    expect_st(S_SOFT, "R9 stays soft");

    // R4 early enable
    do_reset();
    retires(10);
    cyc(1'b0, 1'b1, W_EN);
    expect_st(S_OPEN, "R4 early enable");

    // R4 lock from countdown, R5 enable+sticky ignored
    do_reset();
    retires(3);
    cyc(1'b0, 1'b1, W_LOCK);
    expect_st(S_LOCK, "R4 lock in countdown");
    cyc(1'b0, 1'b1, W_ENST);
    expect_st(S_LOCK, "R5 write ignored");

    // R4 enable bit dominates sticky bit; R5 reset clears lock
    do_reset();
    expect_st(S_CNT, "R5 reset clears lock");
    cyc(1'b0, 1'b1, W_ENST);
    expect_st(S_OPEN, "R4 sticky ignored on enable");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule